// File: doc/BRIEF.md
# Length-autodetecting three-wire write slave

This block receives write commands over a three-wire serial link (clock, active-high select, data) and turns each good frame into one register write inside the chip. The link is write-only. While select is high the block counts rising serial clock edges and shifts the data in, most significant bit first. The count decides the frame format anew for every frame. A count of 32 means a frame with a two-bit header. A count of 30 means the same frame with the header left out. Any other count means the frame is thrown away.

All three serial lines are oversampled in the core clock domain. Each line passes through a synchroniser, and edges are found by comparing each synchronised level with its value one cycle earlier. When the synchronised select falls, the captured frame is judged:
- The header and the eight fixed device-identity bits are checked first. A mismatch raises a one-cycle error pulse.
- A read request, or a register number that is not defined, is dropped without any signal.
- A good write sets the 5-bit register number and the 16-bit data on the outputs and raises a one-cycle write strobe.

The register file that consumes the strobe sits outside this block.

Top module: `sw3_autolen_slave`

## Requirements
- R1: While `rst_n` is low and for the cycles right after its release, `wr_stb` and `err_stb` are 0 and `wr_addr` and `wr_data` are 0. A reset during a frame discards the partial frame.
- R2: A bit is taken on each rising edge of `ser_clk` seen while `ser_sel` is high, with the first bit taken being the most significant. The frame length is the number of such edges.
- R3: A frame is judged only when `ser_sel` falls. With a length other than 30 or 32, the frame causes no strobe and no error pulse, and `wr_addr`/`wr_data` keep their values.
- R4: The edge count saturates at 33. A frame of any length above 32 (for example 40 or 94 edges) is never accepted, even when its last 30 or 32 bits would form a valid frame.
- R5: In a 32-bit frame, the first two bits received must both be 1. The fields then follow in this order: the R/W bit, a 13-bit address sent from its top bit down, and 16 data bits sent from bit 15 down. A frame whose first two bits are not 11 produces an error pulse.
- R6: A 30-bit frame has the same layout without the two header bits: the R/W bit, the 13-bit address, then the 16 data bits.
- R7: R/W = 1 marks a read, which is not supported. Such a frame, if its header and identity are good, produces neither a strobe nor an error.
- R8: The top eight address bits (address bits 12 to 5) must equal 1010_0100. A mismatch, or a bad header, produces exactly one `err_stb` cycle with no strobe and no change of `wr_addr`/`wr_data`. This check takes precedence over R7 and R9.
- R9: The low five address bits are the register number. Only 0 to 5 and 16 are written. Any other value, including 17 to 31, produces neither a strobe nor an error.
- R10: An accepted frame produces exactly one `wr_stb` cycle, a few core cycles after `ser_sel` falls. `wr_addr`/`wr_data` carry that frame's register number and data from the strobe cycle until the next accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, sampled on its rising edge |
| ser_sel | input | 1 | Serial frame select, active high |
| ser_data | input | 1 | Serial data, MSB first |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Register number of the last accepted write |
| wr_data | output | 16 | Data of the last accepted write |
| err_stb | output | 1 | One-cycle pulse for a frame with a bad header or identity |

## Verification
The bench sends frames of 29, 30, 31 and 32 bits. A design that mixes up the two layouts, or ignores the length, would write on the 31-bit frame, whose low 30 bits are a valid short frame. Overlong frames of 40 and 94 edges carry valid trailing bits: a counter that wraps at 64 would read 94 edges as 30 and write. Read requests, reserved register numbers and identity or header errors are each sent, so that an error raised where silence is required, or a write leaking through, shows up in the strobe and error counts and in the held address and data. A reset in the middle of a frame and a strobe that lasts longer than one cycle are also checked.

// File: rtl/sw3_pkg.sv
package sw3_pkg;

  // frame geometry
  localparam int LONG_LEN  = 32;
  localparam int SHORT_LEN = 30;
  localparam int HDR_W     = LONG_LEN - SHORT_LEN;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 13;
  localparam int REG_W     = 5;
  localparam int ID_W      = ADDR_W - REG_W;
  localparam int RW_POS    = DATA_W + ADDR_W;

  // counter saturates one above the longest legal frame
  localparam int CNT_SAT   = LONG_LEN + 1;
  localparam int CNT_W     = $clog2(CNT_SAT + 1);

  localparam logic [ID_W-1:0]  DEV_ID       = 8'b1010_0100;
  localparam logic [REG_W-1:0] REG_LOW_LAST = 5'd5;
  localparam logic [REG_W-1:0] REG_MODE     = 5'd16;

  typedef enum logic [1:0] {
    VERDICT_DROP  = 2'd0,
    VERDICT_WRITE = 2'd1,
    VERDICT_ERROR = 2'd2
  } verdict_e;

  typedef struct packed {
    logic [REG_W-1:0]  reg_num;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;

  function automatic logic reg_is_defined(input logic [REG_W-1:0] r);
    return (r <= REG_LOW_LAST) || (r == REG_MODE);
  endfunction

endpackage

// File: rtl/sw3_line_sync.sv
module sw3_line_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_in[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign d_out[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/sw3_frame_capture.sv
module sw3_frame_capture
  import sw3_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_s,
  input  logic                ssel_s,
  input  logic                sdat_s,
  output logic                frame_end,
  output logic [LONG_LEN-1:0] frame_bits,
  output logic [CNT_W-1:0]    frame_len
);

  logic                clk_prev_q, sel_prev_q;
  logic [LONG_LEN-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                shift_en;
  logic                clk_rise;

  assign clk_rise = sclk_s & ~clk_prev_q;
  assign shift_en = ssel_s & clk_rise;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    if (!ssel_s) begin
      cnt_d = '0;
    end else if (shift_en) begin
      shift_d = {shift_q[LONG_LEN-2:0], sdat_s};
      if (cnt_q != CNT_W'(CNT_SAT)) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      sel_prev_q <= 1'b0;
      shift_q    <= '0;
      cnt_q      <= '0;
    end else begin
      clk_prev_q <= sclk_s;
      sel_prev_q <= ssel_s;
      if (shift_en) begin
        shift_q <= shift_d;
      end
      cnt_q <= cnt_d;
    end
  end

  assign frame_end  = sel_prev_q & ~ssel_s;
  assign frame_bits = shift_q;
  assign frame_len  = cnt_q;

endmodule

// File: rtl/sw3_frame_judge.sv
module sw3_frame_judge
  import sw3_pkg::*;
(
  input  logic [LONG_LEN-1:0] frame_bits,
  input  logic [CNT_W-1:0]    frame_len,
  output verdict_e            verdict,
  output wr_cmd_t             cmd
);

  logic              is_long, is_short;
  logic [HDR_W-1:0]  hdr;
  logic              rw;
  logic [ADDR_W-1:0] addr;
  logic [ID_W-1:0]   id;

  always_comb begin
    is_long  = (frame_len == CNT_W'(LONG_LEN));
    is_short = (frame_len == CNT_W'(SHORT_LEN));
    hdr      = frame_bits[LONG_LEN-1 -: HDR_W];
    rw       = frame_bits[RW_POS];
    addr     = frame_bits[DATA_W +: ADDR_W];
    id       = addr[ADDR_W-1 -: ID_W];

    cmd.reg_num = addr[REG_W-1:0];
    cmd.data    = frame_bits[DATA_W-1:0];

    if (!(is_long || is_short)) begin
      verdict = VERDICT_DROP;
    end else if (is_long && (hdr != '1)) begin
      verdict = VERDICT_ERROR;
    end else if (id != DEV_ID) begin
      verdict = VERDICT_ERROR;
    end else if (rw) begin
      verdict = VERDICT_DROP;
    end else if (!reg_is_defined(addr[REG_W-1:0])) begin
      verdict = VERDICT_DROP;
    end else begin
      verdict = VERDICT_WRITE;
    end
  end

endmodule

// File: rtl/sw3_cmd_out.sv
module sw3_cmd_out
  import sw3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  verdict_e          verdict,
  input  wr_cmd_t           cmd,
  output logic              wr_stb,
  output logic [REG_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              err_stb
);

  logic    stb_q, stb_d, err_q, err_d, load_en;
  wr_cmd_t cmd_q;

  always_comb begin
    load_en = frame_end && (verdict == VERDICT_WRITE);
    stb_d   = load_en;
    err_d   = frame_end && (verdict == VERDICT_ERROR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      err_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      stb_q <= stb_d;
      err_q <= err_d;
      if (load_en) begin
        cmd_q <= cmd;
      end
    end
  end

  assign wr_stb  = stb_q;
  assign err_stb = err_q;
  assign wr_addr = cmd_q.reg_num;
  assign wr_data = cmd_q.data;

endmodule

// File: rtl/sw3_autolen_slave.sv
module sw3_autolen_slave
  import sw3_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_sel,
  input  logic        ser_data,
  output logic        wr_stb,
  output logic [4:0]  wr_addr,
  output logic [15:0] wr_data,
  output logic        err_stb
);

  // reset: asserted asynchronously, released after RST_STAGES clocks
  logic [RST_STAGES-1:0] rst_chain_q, rst_chain_d;
  logic                  core_rst_n;

  always_comb begin
    rst_chain_d = {rst_chain_q[RST_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_chain_q <= '0;
    end else begin
      rst_chain_q <= rst_chain_d;
    end
  end

  assign core_rst_n = rst_chain_q[RST_STAGES-1];

  logic [2:0]          lines_s;
  logic                frame_end;
  logic [LONG_LEN-1:0] frame_bits;
  logic [CNT_W-1:0]    frame_len;
  verdict_e            verdict;
  wr_cmd_t             cmd;

  sw3_line_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d_in  ({ser_data, ser_sel, ser_clk}),
    .d_out (lines_s)
  );

  sw3_frame_capture u_cap (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .sclk_s     (lines_s[0]),
    .ssel_s     (lines_s[1]),
    .sdat_s     (lines_s[2]),
    .frame_end  (frame_end),
    .frame_bits (frame_bits),
    .frame_len  (frame_len)
  );

  sw3_frame_judge u_judge (
    .frame_bits (frame_bits),
    .frame_len  (frame_len),
    .verdict    (verdict),
    .cmd        (cmd)
  );

  sw3_cmd_out u_out (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .frame_end (frame_end),
    .verdict   (verdict),
    .cmd       (cmd),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .err_stb   (err_stb)
  );

endmodule

// File: rtl/sw3_autolen_slave_chk.sv
module sw3_autolen_slave_chk
  import sw3_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             err_stb,
  input logic [4:0]       wr_addr,
  input logic [15:0]      wr_data,
  input logic             frame_end,
  input logic [CNT_W-1:0] frame_len
);

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R10

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |=> !err_stb); // R8

  AST_STB_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && err_stb)); // R8

  AST_STB_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(frame_end)); // R10

  AST_REG_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ((wr_addr <= 5'd5) || (wr_addr == 5'd16))); // R9

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> ($stable(wr_addr) && $stable(wr_data))); // R3

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    frame_len <= CNT_W'(CNT_SAT)); // R4

endmodule

bind sw3_autolen_slave sw3_autolen_slave_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_stb    (wr_stb),
  .err_stb   (err_stb),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .frame_end (frame_end),
  .frame_len (frame_len)
);

// File: tb/sw3_autolen_slave_tb_top.sv
module sw3_autolen_slave_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_sel = 1'b0;
  logic        ser_data = 1'b0;
  logic        wr_stb, err_stb;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;

  int checks = 0;
  int errors = 0;
  int stb_seen = 0;
  int err_seen = 0;
  int stb_run = 0;
  int max_run = 0;

  always #4 clk = ~clk; // 125 MHz

  sw3_autolen_slave dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_sel  (ser_sel),
    .ser_data (ser_data),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .err_stb  (err_stb)
  );

  // frame field order: hdr(2) rw(1) id(8) reg(5) data(16)
  function automatic logic [31:0] mk(input logic [1:0] hdr, input logic rw,
                                     input logic [7:0] id, input logic [4:0] rn,
                                     input logic [15:0] dat);
    return {hdr, rw, id, rn, dat};
  endfunction

  typedef struct packed {
    logic [6:0]  len;
    logic [31:0] bits;
    logic        stb;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{7'd32, mk(2'b11, 1'b0, 8'hA4, 5'd0,  16'h1234), 1'b1, 1'b0, 4'd5},  // R5
    '{7'd30, mk(2'b00, 1'b0, 8'hA4, 5'd5,  16'hABCD), 1'b1, 1'b0, 4'd6},  // R6
    '{7'd32, mk(2'b11, 1'b0, 8'hA4, 5'd16, 16'h00FF), 1'b1, 1'b0, 4'd9},  // R9
    '{7'd30, mk(2'b00, 1'b0, 8'hA4, 5'd17, 16'h5A5A), 1'b0, 1'b0, 4'd9},  // R9
    '{7'd32, mk(2'b11, 1'b0, 8'hA4, 5'd31, 16'h1111), 1'b0, 1'b0, 4'd9},  // R9
    '{7'd32, mk(2'b10, 1'b0, 8'hA4, 5'd1,  16'h2222), 1'b0, 1'b1, 4'd5},  // R5
    '{7'd32, mk(2'b11, 1'b0, 8'hA5, 5'd1,  16'h3333), 1'b0, 1'b1, 4'd8},  // R8
    '{7'd30, mk(2'b00, 1'b0, 8'h24, 5'd2,  16'h4444), 1'b0, 1'b1, 4'd8},  // R8
    '{7'd32, mk(2'b11, 1'b1, 8'hA4, 5'd1,  16'h6666), 1'b0, 1'b0, 4'd7},  // R7
    '{7'd30, mk(2'b00, 1'b1, 8'hA4, 5'd4,  16'h7777), 1'b0, 1'b0, 4'd7},  // R7
    '{7'd31, mk(2'b01, 1'b0, 8'hA4, 5'd1,  16'h5555), 1'b0, 1'b0, 4'd3},  // R3
    '{7'd29, mk(2'b00, 1'b0, 8'hA4, 5'd2,  16'h0F0F), 1'b0, 1'b0, 4'd3},  // R3
    '{7'd30, mk(2'b00, 1'b0, 8'hA4, 5'd3,  16'h0000), 1'b1, 1'b0, 4'd2},  // R2
    '{7'd32, mk(2'b11, 1'b0, 8'hA4, 5'd2,  16'hFFFF), 1'b1, 1'b0, 4'd5}   // R5
  };

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_seen++;
      stb_run++;
      if (stb_run > max_run) max_run = stb_run;
    end else begin
      stb_run = 0;
    end
    if (err_stb) err_seen++;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [95:0] bits, input int n);
    @(negedge clk) ser_sel = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    ser_sel = 1'b0;
    ser_data = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  logic [4:0]  m_addr = '0;
  logic [15:0] m_data = '0;

  task automatic expect_frame(input string req, input int s0, input int e0,
                              input int ds, input int de);
    chk(req, "strobe count", 32'(stb_seen - s0), 32'(ds));
    chk(req, "error count", 32'(err_seen - e0), 32'(de));
    chk(req, "wr_addr", 32'(wr_addr), 32'(m_addr));
    chk(req, "wr_data", 32'(wr_data), 32'(m_data));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1", "wr_stb in reset", 32'(wr_stb), 0);
    chk("R1", "err_stb in reset", 32'(err_stb), 0);
    chk("R1", "wr_addr in reset", 32'(wr_addr), 0);
    chk("R1", "wr_data in reset", 32'(wr_data), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      int s0, e0;
      string rq;
      s0 = stb_seen;
      e0 = err_seen;
      rq = $sformatf("R%0d", VECS[v].req);
      send({64'd0, VECS[v].bits}, int'(VECS[v].len));
      if (VECS[v].stb) begin
        m_addr = VECS[v].bits[20:16];
        m_data = VECS[v].bits[15:0];
      end
      expect_frame(rq, s0, e0, int'(VECS[v].stb), int'(VECS[v].err));
    end

    // R4: overlong frames whose tails would be valid frames
    begin
      int s0, e0;
      s0 = stb_seen; e0 = err_seen;
      send({64'd0, mk(2'b11, 1'b0, 8'hA4, 5'd1, 16'hBEEF)} | (96'hFF << 32), 40);
      expect_frame("R4", s0, e0, 0, 0);
      s0 = stb_seen; e0 = err_seen;
      send({66'd0, mk(2'b00, 1'b0, 8'hA4, 5'd4, 16'hCAFE)} | (96'h3 << 62), 94);
      expect_frame("R4", s0, e0, 0, 0);
    end

    // R1: reset in the middle of a frame
    @(negedge clk) ser_sel = 1'b1;
    for (int i = 0; i < 10; i++) begin
      ser_data = i[0];
      repeat (2) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    rst_n = 1'b0;
    ser_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "wr_addr after mid-frame reset", 32'(wr_addr), 0);
    chk("R1", "wr_data after mid-frame reset", 32'(wr_data), 0);
    chk("R1", "wr_stb after mid-frame reset", 32'(wr_stb), 0);
    rst_n = 1'b1;
    m_addr = '0; m_data = '0;
    repeat (5) @(negedge clk);
    begin
      int s0, e0;
      s0 = stb_seen; e0 = err_seen;
      send({64'd0, mk(2'b00, 1'b0, 8'hA4, 5'd1, 16'h9876)}, 30);
      m_addr = 5'd1; m_data = 16'h9876;
      expect_frame("R10", s0, e0, 1, 0);
    end

    // R10: every strobe lasted exactly one cycle
    chk("R10", "longest strobe run", 32'(max_run), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule